// File: doc/BRIEF.md
# GPIO Port Controller

This block is one general-purpose I/O port of up to sixteen pins, controlled through a word-wide register interface. Software writes per-pin fields that pick how each pin behaves. The mode can be input, output, alternate function or analog. The other fields select push-pull or open-drain drive, a drive-speed code, a pull resistor and an alternate-function number. From those fields and the output latch, the block computes the drive value, the drive enable, the open-drain flag and the pull controls for every pad.

Pad levels pass through a synchroniser before software can read them. The output latch can be written whole. It can also be changed bit by bit through a write-only port that sets some pins and clears others in a single access, so no read-modify-write is needed. The alternate-function peripherals sit outside the block. Each one presents a value for every pin on a flat input bus.

Reads are combinational, so the read data follows the address within the same cycle. A write takes effect at the clock edge that samples it.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every register reads zero, no pad is driven (pad_oe = 0) and no pull is enabled, so every pin starts as a floating push-pull input at low speed.
- R2: The following word offsets read back what was last written to them: mode 0x00, output type 0x04, speed 0x08, pull 0x0C, output latch 0x14, alternate select for pins 0–7 at 0x20 and alternate select for pins 8–15 at 0x24. The output type and output latch registers hold bits 15:0 only and read zero above bit 15. A register keeps its value in every cycle with no write to its offset.
- R3: The set/clear port is at 0x18. Writing a 1 to bit n (0–15) makes output latch bit n equal to 1. Writing a 1 to bit n+16 makes it 0. Zero bits leave the latch unchanged. Reads of 0x18 return zero.
- R4: When one write to 0x18 has both bit n and bit n+16 at 1, latch bit n becomes 1.
- R5: Offset 0x10 returns the pad levels. A pad change applied before clock edge k is visible after edge k+1. Writes to 0x10 change nothing.
- R6: Offset 0x1C, offsets 0x28–0x3C and any address with bits 1:0 nonzero read zero, and writes to them change no register.
- R7: The mode field of pin p is bits 2p+1:2p, encoded 0 input, 1 output, 2 alternate, 3 analog. In output mode the pad value is latch bit p. In alternate mode the pad value is af_drive[s*16+p], where s is the 4-bit select of pin p. That select is bits 4(p mod 8)+3:4(p mod 8) of 0x20 for pins 0–7 and of 0x24 for pins 8–15.
- R8: Output type bit p (0 push-pull, 1 open-drain) is presented on pad_od[p]. An open-drain pin in output or alternate mode has pad_out = 0, and it drives (pad_oe = 1) only when its value is 0.
- R9: Pull field bits 2p+1:2p select 1 pull-up and 2 pull-down. Codes 0 and 3, and analog mode, enable neither pull, and pad_pu and pad_pd are never both 1.
- R10: In input and analog modes pad_oe and pad_out of that pin are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the register interface |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pad_in | input | PINS | Raw pad levels |
| af_drive | input | NUM_AF*PINS | Alternate-function values, function f for pin p at bit f*PINS+p |
| pad_out | output | PINS | Pad drive value |
| pad_oe | output | PINS | Pad drive enable |
| pad_od | output | PINS | Open-drain flag per pin |
| pad_pu | output | PINS | Pull-up enable |
| pad_pd | output | PINS | Pull-down enable |

## Verification
A wrong mode, select or output-type bit shows on the pad outputs in the cycle after the write that sets it, because the pad controls are combinational from the registers. A corrupted latch bit shows both on the pad and on the 0x14 read-back at the next sample. A fault in the synchroniser shows as input data that arrives one edge early or one edge late. Set/clear priority faults show only on a write that sets and clears the same pin, so that case is driven directly as well as by random data.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   typedef enum logic [1:0] {
      PM_IN  = 2'd0,
      PM_OUT = 2'd1,
      PM_ALT = 2'd2,
      PM_ANA = 2'd3
   } pin_mode_e;

   localparam logic [1:0] PULL_UP   = 2'd1;
   localparam logic [1:0] PULL_DOWN = 2'd2;

   // word index = byte offset / 4
   localparam logic [3:0] W_MODE   = 4'h0;
   localparam logic [3:0] W_OTYPE  = 4'h1;
   localparam logic [3:0] W_SPEED  = 4'h2;
   localparam logic [3:0] W_PULL   = 4'h3;
   localparam logic [3:0] W_IDATA  = 4'h4;
   localparam logic [3:0] W_ODATA  = 4'h5;
   localparam logic [3:0] W_SETCLR = 4'h6;
   localparam logic [3:0] W_AFLO   = 4'h8;
   localparam logic [3:0] W_AFHI   = 4'h9;
   localparam logic [3:0] W_NONE   = 4'hF;

   localparam int SEL_W = 4;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int PINS   = 16,
   parameter int STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PINS-1:0] d,
   output logic [PINS-1:0] q
);

   logic [PINS-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= '0;
      end else begin
         stg[0] <= d;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];

   generate
      if (STAGES == 2) begin : g_chk2
         logic [1:0] age;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          age <= 2'd0;
            else if (age != 2'd2) age <= age + 2'd1;
         end
         AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
            (age == 2'd2) |-> (q == $past(d, 2))) else $error("sync latency"); // R5
      end
   endgenerate

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
   import gpio_port_pkg::*;
#(
   parameter int PINS = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [3:0]                 idx,
   input  logic [31:0]                wdata,
   output logic [31:0]                rdata,
   input  logic [PINS-1:0]            idata,
   output logic [PINS-1:0][1:0]       mode_o,
   output logic [PINS-1:0]            otype_o,
   output logic [PINS-1:0][1:0]       pull_o,
   output logic [PINS-1:0]            odr_o,
   output logic [PINS-1:0][SEL_W-1:0] afsel_o
);

   logic [PINS-1:0][1:0]       mode_r;
   logic [PINS-1:0][1:0]       speed_r;
   logic [PINS-1:0][1:0]       pull_r;
   logic [PINS-1:0]            otype_r;
   logic [PINS-1:0]            odr_r;
   logic [PINS-1:0][SEL_W-1:0] af_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_r  <= '0;
         speed_r <= '0;
         pull_r  <= '0;
         otype_r <= '0;
         odr_r   <= '0;
         af_r    <= '0;
      end else if (wr_en) begin
         case (idx)
            W_MODE:  for (int p = 0; p < PINS; p++) mode_r[p]  <= wdata[2*p +: 2];
            W_SPEED: for (int p = 0; p < PINS; p++) speed_r[p] <= wdata[2*p +: 2];
            W_PULL:  for (int p = 0; p < PINS; p++) pull_r[p]  <= wdata[2*p +: 2];
            W_OTYPE: otype_r <= wdata[PINS-1:0];
            W_ODATA: odr_r   <= wdata[PINS-1:0];
            W_SETCLR: begin
               for (int p = 0; p < PINS; p++) begin
                  if (wdata[p])           odr_r[p] <= 1'b1;
                  else if (wdata[16 + p]) odr_r[p] <= 1'b0;
               end
            end
            W_AFLO: begin
               for (int p = 0; p < PINS; p++)
                  if (p < 8) af_r[p] <= wdata[4*(p%8) +: 4];
            end
            W_AFHI: begin
               for (int p = 0; p < PINS; p++)
                  if (p >= 8) af_r[p] <= wdata[4*(p%8) +: 4];
            end
            default: ;
         endcase
      end
   end

   logic [31:0] rb_mode, rb_speed, rb_pull, rb_aflo, rb_afhi;

   always_comb begin
      rb_mode  = '0;
      rb_speed = '0;
      rb_pull  = '0;
      rb_aflo  = '0;
      rb_afhi  = '0;
      for (int p = 0; p < PINS; p++) begin
         rb_mode[2*p +: 2]  = mode_r[p];
         rb_speed[2*p +: 2] = speed_r[p];
         rb_pull[2*p +: 2]  = pull_r[p];
         if (p < 8) rb_aflo[4*(p%8) +: 4] = af_r[p];
         else       rb_afhi[4*(p%8) +: 4] = af_r[p];
      end
   end

   always_comb begin
      case (idx)
         W_MODE:  rdata = rb_mode;
         W_OTYPE: rdata = 32'(otype_r);
         W_SPEED: rdata = rb_speed;
         W_PULL:  rdata = rb_pull;
         W_IDATA: rdata = 32'(idata);
         W_ODATA: rdata = 32'(odr_r);
         W_AFLO:  rdata = rb_aflo;
         W_AFHI:  rdata = rb_afhi;
         default: rdata = '0;
      endcase
   end

   assign mode_o  = mode_r;
   assign otype_o = otype_r;
   assign pull_o  = pull_r;
   assign odr_o   = odr_r;
   assign afsel_o = af_r;

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && idx == W_SETCLR) |=>
      ((odr_r & $past(wdata[PINS-1:0])) == $past(wdata[PINS-1:0])))
      else $error("set bit not applied"); // R4
   AST_CLEAR_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && idx == W_SETCLR) |=>
      ((odr_r & $past(wdata[16 +: PINS] & ~wdata[PINS-1:0])) == '0))
      else $error("clear bit not applied"); // R3
   AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (idx == W_SETCLR || idx == W_ODATA)) |=> $stable(odr_r))
      else $error("latch changed without write"); // R2

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
   import gpio_port_pkg::*;
#(
   parameter int PINS   = 16,
   parameter int NUM_AF = 16
) (
   input  logic [PINS-1:0][1:0]       mode_i,
   input  logic [PINS-1:0]            otype_i,
   input  logic [PINS-1:0][1:0]       pull_i,
   input  logic [PINS-1:0]            odr_i,
   input  logic [PINS-1:0][SEL_W-1:0] afsel_i,
   input  logic [NUM_AF*PINS-1:0]     af_bus_i,
   output logic [PINS-1:0]            pad_out_o,
   output logic [PINS-1:0]            pad_oe_o,
   output logic [PINS-1:0]            pad_od_o,
   output logic [PINS-1:0]            pad_pu_o,
   output logic [PINS-1:0]            pad_pd_o
);

   localparam int NSEL = 1 << SEL_W;

   for (genvar p = 0; p < PINS; p++) begin : g_pin
      logic [NSEL-1:0] af_col;
      logic            drives;
      logic            val;
      logic            analog;

      for (genvar f = 0; f < NSEL; f++) begin : g_fn
         if (f < NUM_AF) begin : g_used
            assign af_col[f] = af_bus_i[f*PINS + p];
         end else begin : g_unused
            assign af_col[f] = 1'b0;
         end
      end

      always_comb begin
         case (pin_mode_e'(mode_i[p]))
            PM_OUT:  begin drives = 1'b1; val = odr_i[p];            end
            PM_ALT:  begin drives = 1'b1; val = af_col[afsel_i[p]];  end
            default: begin drives = 1'b0; val = 1'b0;                end
         endcase
      end

      assign analog       = (pin_mode_e'(mode_i[p]) == PM_ANA);
      assign pad_oe_o[p]  = drives & (~otype_i[p] | ~val);
      assign pad_out_o[p] = drives & ~otype_i[p] & val;
      assign pad_od_o[p]  = otype_i[p];
      assign pad_pu_o[p]  = ~analog & (pull_i[p] == PULL_UP);
      assign pad_pd_o[p]  = ~analog & (pull_i[p] == PULL_DOWN);
   end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
   import gpio_port_pkg::*;
#(
   parameter int PINS        = 16,
   parameter int NUM_AF      = 16,
   parameter int ADDR_W      = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   reg_wr,
   input  logic [ADDR_W-1:0]      reg_addr,
   input  logic [31:0]            reg_wdata,
   output logic [31:0]            reg_rdata,
   input  logic [PINS-1:0]        pad_in,
   input  logic [NUM_AF*PINS-1:0] af_drive,
   output logic [PINS-1:0]        pad_out,
   output logic [PINS-1:0]        pad_oe,
   output logic [PINS-1:0]        pad_od,
   output logic [PINS-1:0]        pad_pu,
   output logic [PINS-1:0]        pad_pd
);

   if (PINS < 1 || PINS > 16) begin : g_bad_pins
      $error("PINS must be 1..16");
   end
   if (NUM_AF < 1 || NUM_AF > (1 << SEL_W)) begin : g_bad_af
      $error("NUM_AF must be 1..16");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("ADDR_W must be at least 6");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic       hit;
   logic [3:0] word_idx;

   if (ADDR_W > 6) begin : g_wide_addr
      assign hit = (reg_addr[1:0] == 2'b00) && (reg_addr[ADDR_W-1:6] == '0);
   end else begin : g_narrow_addr
      assign hit = (reg_addr[1:0] == 2'b00);
   end
   assign word_idx = hit ? reg_addr[5:2] : W_NONE;

   logic [PINS-1:0]            idata;
   logic [PINS-1:0][1:0]       mode_q;
   logic [PINS-1:0]            otype_q;
   logic [PINS-1:0][1:0]       pull_q;
   logic [PINS-1:0]            odr_q;
   logic [PINS-1:0][SEL_W-1:0] afsel_q;

   gpio_in_sync #(.PINS(PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (idata)
   );

   gpio_regfile #(.PINS(PINS)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr),
      .idx     (word_idx),
      .wdata   (reg_wdata),
      .rdata   (reg_rdata),
      .idata   (idata),
      .mode_o  (mode_q),
      .otype_o (otype_q),
      .pull_o  (pull_q),
      .odr_o   (odr_q),
      .afsel_o (afsel_q)
   );

   gpio_pad_drive #(.PINS(PINS), .NUM_AF(NUM_AF)) u_pads (
      .mode_i    (mode_q),
      .otype_i   (otype_q),
      .pull_i    (pull_q),
      .odr_i     (odr_q),
      .afsel_i   (afsel_q),
      .af_bus_i  (af_drive),
      .pad_out_o (pad_out),
      .pad_oe_o  (pad_oe),
      .pad_od_o  (pad_od),
      .pad_pu_o  (pad_pu),
      .pad_pd_o  (pad_pd)
   );

   AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe & pad_od & pad_out) == '0)) else $error("open-drain drove high"); // R8
   AST_PULL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_pu & pad_pd) == '0)) else $error("both pulls on"); // R9
   AST_OUT_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_out & ~pad_oe) == '0)) else $error("value without enable"); // R10

endmodule

// File: tb/tb_gpio_port_ctrl.sv
module tb_gpio_port_ctrl;

   localparam int PINS   = 16;
   localparam int NUM_AF = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [PINS-1:0] pad_in = '0;
   logic [NUM_AF*PINS-1:0] af_drive = '0;
   logic [PINS-1:0] pad_out, pad_oe, pad_od, pad_pu, pad_pd;

   always #5 clk = ~clk;

   gpio_port_ctrl dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
      .af_drive(af_drive), .pad_out(pad_out), .pad_oe(pad_oe),
      .pad_od(pad_od), .pad_pu(pad_pu), .pad_pd(pad_pd)
   );

   int n_checks = 0;
   int n_fail   = 0;

   // reference model
   logic [31:0] m_mode = '0, m_speed = '0, m_pull = '0, m_aflo = '0, m_afhi = '0;
   logic [15:0] m_otype = '0, m_odr = '0;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_write(logic [5:0] a, logic [31:0] d);
      if (a[1:0] == 2'b00) begin
         case (a[5:2])
            4'h0: m_mode  = d;
            4'h1: m_otype = d[15:0];
            4'h2: m_speed = d;
            4'h3: m_pull  = d;
            4'h5: m_odr   = d[15:0];
            4'h6: for (int p = 0; p < 16; p++) begin
                     if (d[p])           m_odr[p] = 1'b1;
                     else if (d[16 + p]) m_odr[p] = 1'b0;
                  end
            4'h8: m_aflo = d;
            4'h9: m_afhi = d;
            default: ;
         endcase
      end
   endtask

   function automatic logic [31:0] exp_rd(logic [5:0] a);
      if (a[1:0] != 2'b00) return '0;
      case (a[5:2])
         4'h0: return m_mode;
         4'h1: return {16'h0, m_otype};
         4'h2: return m_speed;
         4'h3: return m_pull;
         4'h4: return {16'h0, pad_in};
         4'h5: return {16'h0, m_odr};
         4'h8: return m_aflo;
         4'h9: return m_afhi;
         default: return '0;
      endcase
   endfunction

   function automatic logic [79:0] exp_pads();
      logic [15:0] o, oe, od, pu, pd;
      for (int p = 0; p < 16; p++) begin
         logic [1:0] md;
         logic [3:0] s;
         logic v, drv;
         md  = m_mode[2*p +: 2];
         s   = (p < 8) ? m_aflo[4*(p%8) +: 4] : m_afhi[4*(p%8) +: 4];
         drv = (md == 2'd1) || (md == 2'd2);
         v   = (md == 2'd1) ? m_odr[p] : (md == 2'd2) ? af_drive[int'(s)*16 + p] : 1'b0;
         od[p] = m_otype[p];
         oe[p] = drv && (!m_otype[p] || !v);
         o[p]  = drv && !m_otype[p] && v;
         pu[p] = (md != 2'd3) && (m_pull[2*p +: 2] == 2'd1);
         pd[p] = (md != 2'd3) && (m_pull[2*p +: 2] == 2'd2);
      end
      return {o, oe, od, pu, pd};
   endfunction

   task automatic wr(logic [5:0] a, logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
      model_write(a, d);
   endtask

   task automatic rd_chk(logic [5:0] a, string tag);
      reg_addr = a;
      #1;
      chk(tag, reg_rdata, exp_rd(a));
   endtask

   task automatic chk_regs(string tag);
      for (int w = 0; w < 10; w++) rd_chk(6'(w * 4), tag);
   endtask

   task automatic chk_pads(string tag);
      logic [79:0] e;
      #1;
      e = exp_pads();
      chk({tag, " pad_out"}, 32'(pad_out), 32'(e[79:64]));
      chk({tag, " pad_oe"},  32'(pad_oe),  32'(e[63:48]));
      chk({tag, " pad_od"},  32'(pad_od),  32'(e[47:32]));
      chk({tag, " pad_pu"},  32'(pad_pu),  32'(e[31:16]));
      chk({tag, " pad_pd"},  32'(pad_pd),  32'(e[15:0]));
   endtask

   task automatic rand_af();
      for (int i = 0; i < 8; i++) af_drive[32*i +: 32] = $urandom;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk_regs("R1 reset readback");
      chk_pads("R1 reset pads");
      chk("R1 no drive after reset", 32'(pad_oe), 32'h0);

      // R2 readback incl. upper bits dropped
      wr(6'h04, 32'hFFFF_0000);
      wr(6'h08, 32'h1234_5678);
      wr(6'h20, 32'hFEDC_BA98);
      wr(6'h24, 32'h7654_3210);
      chk_regs("R2 readback");
      rd_chk(6'h04, "R2 otype upper bits zero");
      wr(6'h04, 32'h0);

      // R7 output mode
      wr(6'h00, 32'h5555_5555);
      wr(6'h14, 32'hFFFF_A5A5);
      chk_regs("R2 latch readback");
      chk_pads("R7 output mode");
      chk("R7 pad_out equals latch", 32'(pad_out), 32'h0000_A5A5);

      // R3/R4 set-clear
      wr(6'h18, 32'h0003_0001);
      chk("R4 set wins over clear pin0", {31'h0, pad_out[0]}, 32'h1);
      chk("R3 clear pin1", {31'h0, pad_out[1]}, 32'h0);
      rd_chk(6'h14, "R3 latch after set-clear");
      rd_chk(6'h18, "R3 set-clear reads zero");
      wr(6'h18, 32'h0000_0000);
      rd_chk(6'h14, "R3 zero write no effect");
      wr(6'h18, 32'hFFFF_FFFF);
      chk("R4 all set", 32'(pad_out), 32'h0000_FFFF);
      wr(6'h18, 32'hFFFF_0000);
      chk("R3 all clear", 32'(pad_out), 32'h0);

      // R8 open-drain
      wr(6'h14, 32'h0000_F0F0);
      wr(6'h04, 32'h0000_FF00);
      chk_pads("R8 open drain");
      chk("R8 od pins never high", 32'(pad_out & pad_od), 32'h0);

      // R7 alternate mode
      rand_af();
      wr(6'h00, 32'hAAAA_AAAA);
      wr(6'h04, 32'h0);
      chk_pads("R7 alternate mode");
      wr(6'h04, 32'h0000_00FF);
      chk_pads("R8 alternate open drain");

      // R9/R10 pulls and mixed modes incl. analog
      wr(6'h0C, 32'h1B1B_E4E4);
      wr(6'h00, 32'hE4E4_1B1B);
      chk_pads("R9 pulls mixed modes");
      wr(6'h00, 32'h0);
      chk_pads("R10 input mode no drive");
      wr(6'h00, 32'hFFFF_FFFF);
      chk_pads("R10 analog mode");
      chk("R9 analog no pulls", 32'(pad_pu | pad_pd), 32'h0);

      // R5 synchroniser latency
      pad_in = 16'h0000;
      repeat (3) @(negedge clk);
      pad_in = 16'hC3A5;
      @(negedge clk);
      reg_addr = 6'h10; #1;
      chk("R5 not visible after one edge", reg_rdata, 32'h0);
      @(negedge clk);
      reg_addr = 6'h10; #1;
      chk("R5 visible after two edges", reg_rdata, 32'h0000_C3A5);
      wr(6'h10, 32'hFFFF_FFFF);
      chk_regs("R5 write to input data ignored");

      // R6 lock, unmapped, misaligned
      wr(6'h1C, 32'hFFFF_FFFF);
      wr(6'h28, 32'hFFFF_FFFF);
      wr(6'h3C, 32'hFFFF_FFFF);
      wr(6'h01, 32'hFFFF_FFFF);
      wr(6'h16, 32'h0000_FFFF);
      rd_chk(6'h1C, "R6 lock reads zero");
      rd_chk(6'h2C, "R6 unmapped reads zero");
      rd_chk(6'h02, "R6 misaligned reads zero");
      chk_regs("R6 ignored writes");
      chk_pads("R6 pads unchanged");

      // random mix
      for (int it = 0; it < 400; it++) begin
         logic [5:0] a;
         pad_in = 16'($urandom);
         if (($urandom % 8) == 0) rand_af();
         a = ($urandom % 4 == 0) ? 6'($urandom) : 6'(($urandom % 10) * 4);
         wr(a, $urandom);
         @(negedge clk);
         rd_chk(6'(($urandom % 16) * 4), "R2 random readback");
         rd_chk(6'h14, "R3 random latch");
         rd_chk(6'h10, "R5 random input data");
         chk_pads("R7 random pads");
      end

      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule